// File: doc/BRIEF.md
# Multi-Vector Accumulator Group Sequencer

This block steers one multi-register multiply-accumulate into a banked accumulator array. A single start pulse captures a group mode (two or four groups), a select for the base register, the 32-bit value read from that register, a 3-bit immediate offset, the index of the first source register and the index of the shared second source register. The block then steps through the groups, one per cycle. For each step it issues register-file read indices, an accumulator row address and a read enable. One cycle later it issues a write-back enable for the same row, with every 16-bit lane enabled.

The register files, the accumulator storage and the BFloat16 fused multiply-add lanes are outside the block. The accumulator array holds VL/8 rows and is split into equal groups. The first row is the sum of the base value and the offset, reduced modulo the group stride. Each later step moves one stride further. The first-source index advances by one per step and wraps past 31. The second-source index stays fixed for the whole operation.

If the feature-enable input is low when a start arrives, the block flags an undefined instruction and writes nothing.

Top module: `mva_group_seq`

## Requirements
- R1: `base_idx` is 8 plus `base_sel`, combinationally (`base_sel` = 3 gives 11).
- R2: A start sampled while idle with `feat_en` = 1 raises `busy` on the next cycle and holds it for 2 cycles when `four_grp` = 0, or 4 cycles when `four_grp` = 1.
- R3: Let stride = (VL_BITS/8)/groups. On the first busy cycle, `acc_row` equals (`base_val` + `imm_off`) mod stride. The sum is taken as 32 bits and wraps.
- R4: On each following busy cycle, `acc_row` is the previous row plus stride.
- R5: On busy step r, `rd_a_idx` equals (`src_a_sel` + r) mod 32.
- R6: For the whole operation, `rd_b_idx` equals `src_b_sel` with a 0 prepended as bit 4.
- R7: `acc_rd_en` equals `busy`. Exactly one cycle after each read cycle, `acc_wr_en` is 1, `wr_row` equals that step's row, and `lane_we` is all ones. `acc_wr_en` is 0 at all other times.
- R8: `done` is a one-cycle pulse on the cycle right after the last write-back.
- R9: A start with `feat_en` = 0 gives a one-cycle `undef` pulse on the next cycle. No busy cycle and no write follow it.
- R10: A start that arrives while `busy` or a write-back is pending is ignored. It has no effect on the rows, indices or length of the running operation.
- R11: While reset (`rst_n` = 0) is applied, and just after it, `busy`, `acc_rd_en`, `acc_wr_en`, `done` and `undef` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_en | input | 1 | Operation implemented; when low a start is undefined |
| start | input | 1 | Launch request, sampled when idle |
| four_grp | input | 1 | 0: two groups, 1: four groups |
| base_sel | input | 2 | Base register select |
| base_val | input | 32 | Value read from the base register |
| imm_off | input | 3 | Immediate row offset |
| src_a_sel | input | 5 | First source register index |
| src_b_sel | input | 4 | Shared second source index (registers 0 to 15) |
| base_idx | output | 5 | Base register read index |
| busy | output | 1 | Operation stepping |
| acc_rd_en | output | 1 | Accumulator row read enable |
| rd_a_idx | output | 5 | First source read index |
| rd_b_idx | output | 5 | Second source read index |
| acc_row | output | log2(VL_BITS/8) | Accumulator row being read |
| acc_wr_en | output | 1 | Accumulator write-back enable |
| wr_row | output | log2(VL_BITS/8) | Accumulator row being written |
| lane_we | output | VL_BITS/16 | Per-lane write enable |
| done | output | 1 | Completion pulse |
| undef | output | 1 | Undefined-instruction pulse |

## Verification
The assertions assume that `VL_BITS` is a power of two from 128 to 2048. They also assume that `rst_n` is held low for at least one clock edge before any start, so the stepping state begins clean. The stride and wrap checks further assume that an operation's inputs matter only in the launch cycle. The stimulus drives every input on the falling edge and holds `start` high for exactly one rising edge. It draws random values across the full range of the base value, offset, mode bit and indices, and adds directed cases for 32-bit wrap of the row sum, first-source wrap past 31, a disabled feature and a start issued during an operation.

// File: rtl/mva_group_seq.sv
module mva_group_seq #(
  parameter int VL_BITS = 512,
  localparam int ROWS = VL_BITS / 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int ELEMS = VL_BITS / 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             feat_en,
  input  logic             start,
  input  logic             four_grp,
  input  logic [1:0]       base_sel,
  input  logic [31:0]      base_val,
  input  logic [2:0]       imm_off,
  input  logic [4:0]       src_a_sel,
  input  logic [3:0]       src_b_sel,
  output logic [4:0]       base_idx,
  output logic             busy,
  output logic             acc_rd_en,
  output logic [4:0]       rd_a_idx,
  output logic [4:0]       rd_b_idx,
  output logic [ROW_W-1:0] acc_row,
  output logic             acc_wr_en,
  output logic [ROW_W-1:0] wr_row,
  output logic [ELEMS-1:0] lane_we,
  output logic             done,
  output logic             undef
);
  localparam logic [ROW_W-1:0] STRIDE2 = ROW_W'(ROWS / 2);
  localparam logic [ROW_W-1:0] STRIDE4 = ROW_W'(ROWS / 4);

  initial begin
    p_vl_legal_r3: assert (VL_BITS >= 128 && VL_BITS <= 2048 && (VL_BITS & (VL_BITS - 1)) == 0)
      else $error("VL_BITS must be a power of two in 128..2048");
  end

  logic             four_q;
  logic [1:0]       step;
  logic [31:0]      sum;
  logic [ROW_W-1:0] stride_in, stride_q, first_row;
  logic             launch, last_step;

  assign base_idx  = {3'b010, base_sel};
  assign launch    = start && !busy && !acc_wr_en;
  assign stride_in = four_grp ? STRIDE4 : STRIDE2;
  assign stride_q  = four_q ? STRIDE4 : STRIDE2;
  assign sum       = base_val + {29'd0, imm_off};
  assign first_row = sum[ROW_W-1:0] & (stride_in - 1'b1);
  assign last_step = step == (four_q ? 2'd3 : 2'd1);
  assign acc_rd_en = busy;
  assign lane_we   = {ELEMS{acc_wr_en}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      four_q    <= 1'b0;
      step      <= 2'd0;
      acc_row   <= '0;
      rd_a_idx  <= '0;
      rd_b_idx  <= '0;
      acc_wr_en <= 1'b0;
      wr_row    <= '0;
      done      <= 1'b0;
      undef     <= 1'b0;
    end else begin
      acc_wr_en <= busy;
      wr_row    <= acc_row;
      done      <= acc_wr_en && !busy;
      undef     <= 1'b0;
      if (launch) begin
        if (feat_en) begin
          busy     <= 1'b1;
          four_q   <= four_grp;
          step     <= 2'd0;
          acc_row  <= first_row;
          rd_a_idx <= src_a_sel;
          rd_b_idx <= {1'b0, src_b_sel};
        end else begin
          undef <= 1'b1;
        end
      end else if (busy) begin
        step     <= step + 2'd1;
        acc_row  <= acc_row + stride_q;
        rd_a_idx <= rd_a_idx + 5'd1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

  p_row_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> acc_row == $past(acc_row) + stride_q);
  p_srca_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> rd_a_idx == $past(rd_a_idx) + 5'd1);
  p_srcb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(rd_b_idx) && !rd_b_idx[4]);
  p_wr_follows_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr_en |-> $past(acc_rd_en) && wr_row == $past(acc_row) && (&lane_we));
  p_rd_then_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd_en |=> acc_wr_en);
  p_done_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc_wr_en) && !acc_wr_en && !busy);
  p_undef_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !busy && !acc_wr_en && !done);
  p_run_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
endmodule

// File: tb/mva_group_seq_tb_top.sv
module mva_group_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VL = 512;
  localparam int ROWS = VL / 8;
  localparam int ROW_W = $clog2(ROWS);
  localparam int ELEMS = VL / 16;

  logic clk = 1'b0, rst_n = 1'b0, feat_en = 1'b1, start = 1'b0, four_grp = 1'b0;
  logic [1:0] base_sel = '0;
  logic [31:0] base_val = '0;
  logic [2:0] imm_off = '0;
  logic [4:0] src_a_sel = '0;
  logic [3:0] src_b_sel = '0;
  logic [4:0] base_idx, rd_a_idx, rd_b_idx;
  logic busy, acc_rd_en, acc_wr_en, done, undef;
  logic [ROW_W-1:0] acc_row, wr_row;
  logic [ELEMS-1:0] lane_we;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mva_group_seq #(.VL_BITS(VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .start(start), .four_grp(four_grp),
    .base_sel(base_sel), .base_val(base_val), .imm_off(imm_off), .src_a_sel(src_a_sel),
    .src_b_sel(src_b_sel), .base_idx(base_idx), .busy(busy), .acc_rd_en(acc_rd_en),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .acc_row(acc_row), .acc_wr_en(acc_wr_en),
    .wr_row(wr_row), .lane_we(lane_we), .done(done), .undef(undef));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_row(input logic [31:0] b, input logic [2:0] o, input bit f, input int r);
    int stride;
    logic [31:0] s;
    stride = ROWS / (f ? 4 : 2);
    s = b + 32'(o);
    return int'(s % 32'(stride)) + r * stride;
  endfunction

  task automatic run_op(input bit f, input logic [31:0] b, input logic [2:0] o,
                        input logic [4:0] a, input logic [3:0] m, input bit poke);
    int n;
    n = f ? 4 : 2;
    @(negedge clk);
    four_grp = f; base_val = b; imm_off = o; src_a_sel = a; src_b_sel = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= n + 2; c++) begin
      chk(busy == (c < n), "R2 busy", busy, c < n);
      chk(acc_rd_en == busy, "R7 rd_en", acc_rd_en, busy);
      if (c < n) begin
        chk(acc_row == ROW_W'(exp_row(b, o, f, c)), c == 0 ? "R3 first row" : "R4 row step",
            acc_row, exp_row(b, o, f, c));
        chk(rd_a_idx == 5'(a + c), "R5 src a", rd_a_idx, 5'(a + c));
        chk(rd_b_idx == {1'b0, m}, "R6 src b", rd_b_idx, {1'b0, m});
      end
      chk(acc_wr_en == (c >= 1 && c <= n), "R7 wr_en", acc_wr_en, c >= 1 && c <= n);
      if (c >= 1 && c <= n) begin
        chk(wr_row == ROW_W'(exp_row(b, o, f, c - 1)), "R7 wr row", wr_row, exp_row(b, o, f, c - 1));
        chk(&lane_we, "R7 lanes", lane_we, {ELEMS{1'b1}});
      end
      chk(done == (c == n + 1), "R8 done", done, c == n + 1);
      if (poke && c == 0) begin
        start = 1'b1; src_a_sel = ~a; base_val = ~b; four_grp = ~f;
      end else if (poke && c == 1) begin
        start = 1'b0;  // R10 second start must leave run untouched
      end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !acc_rd_en && !acc_wr_en && !done && !undef, "R11 in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !acc_wr_en && !done && !undef, "R11 after reset", acc_wr_en, 0);

    for (int s = 0; s < 4; s++) begin
      base_sel = 2'(s);
      #1;
      chk(base_idx == 5'(8 + s), "R1 base idx", base_idx, 8 + s);
    end

    run_op(1'b0, 32'h0, 3'd0, 5'd3, 4'd2, 1'b0);
    run_op(1'b1, 32'hFFFF_FFFF, 3'd7, 5'd30, 4'd15, 1'b0);
    run_op(1'b0, 32'hFFFF_FFFC, 3'd5, 5'd31, 4'd0, 1'b0);
    run_op(1'b1, 32'd13, 3'd3, 5'd29, 4'd9, 1'b1);
    run_op(1'b0, 32'd100, 3'd6, 5'd0, 4'd7, 1'b1);

    @(negedge clk);
    feat_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(undef && !busy && !acc_wr_en, "R9 undef pulse", undef, 1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!undef && !busy && !acc_wr_en && !done, "R9 no write", acc_wr_en, 0);
    end
    feat_en = 1'b1;

    for (int i = 0; i < 40; i++)
      run_op(1'($urandom), $urandom, 3'($urandom), 5'($urandom), 4'($urandom), 1'($urandom));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule